// File: doc/BRIEF.md
# Virtual-Link Gap Scheduler

This block decides which virtual link of an end system may start the next frame on a single shared transmit port. Every link has up to four sub-links, each with its own queue. A queue presents a pending flag and the length of the frame at its head. Each link has two configured limits: a minimum spacing between the starts of its frames, and a largest legal frame length. The block grants one link at a time and holds that grant until the transmitter returns a done pulse. A link whose spacing has not yet run out is passed over. A head frame longer than its link's limit is discarded: the block reports it and does not grant it.

The spacing is set per link as a 3-bit exponent. The gap is 2^exponent ticks, so it runs from 1 to 128 ticks, and a tick lasts `TICK_CYCLES` clock cycles. Each link has a countdown that starts when the link is granted. When more than one link may send, the lowest-numbered one goes first. Inside a link, the sub-links take turns. Whenever configuration changes, the block adds up the bandwidth booked by all links and raises a flag if the total exceeds the line rate. Frame data and the queues themselves sit outside this block.

Top module: `vl_gap_sched`

## Requirements
- R1: After reset no grant or drop is active, the overbooking flag is low, and every link may be granted on the first decision.
- R2: `grant_o` is zero or one-hot, and `grant_link_o` is the index of its set bit. A grant appears on the clock edge where the decision is made and stays unchanged until `done_i` is seen on an edge. It is zero after that edge, and the next decision is made on the edge that follows.
- R3: When several links are pending and past their gap, the lowest link index is granted first.
- R4: Exponent e (0 to 7) gives a gap of `TICK_CYCLES << e` cycles. A link's grants are never closer than that many cycles, start to start. A link that is continuously pending, and whose grant was released early, is granted again exactly that many cycles after its previous grant.
- R5: If the length of the selected frame is greater than the link's maximum, `drop_o` pulses for exactly one cycle with the link and sub-link, and there is no grant. A drop does not restart the gap. The next decision is made two edges after the drop decision. A frame whose length equals the maximum is granted.
- R6: Pending flag bit `4*link+sub` and length field bits `[(4*link+sub)*LEN_W +: LEN_W]` belong to one sub-link. Within a link, sub-links are served in turn, starting with the one after the sub-link last granted or dropped. Only pending sub-links are chosen.
- R7: A configuration write sets the exponent and maximum length of the addressed link only. The new maximum applies to the next decision, and the new exponent applies to the next gap that is loaded.
- R8: `over_budget_o` is high when the sum over all links of `lmax << (7-e)` exceeds `BYTES_PER_TICK << 7`. It updates one cycle after the configuration changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | N_LINKS*4 | Pending flag of each sub-link queue |
| flen_i | input | N_LINKS*4*LEN_W | Head frame length of each sub-link queue, in bytes |
| done_i | input | 1 | Pulse: the granted frame has finished |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_link_i | input | $clog2(N_LINKS) | Link addressed by the write |
| cfg_exp_i | input | 3 | Gap exponent written |
| cfg_lmax_i | input | LEN_W | Maximum frame length written |
| grant_o | output | N_LINKS | One-hot grant |
| grant_link_o | output | $clog2(N_LINKS) | Index of the granted link |
| grant_sub_o | output | 2 | Granted sub-link |
| drop_o | output | 1 | One-cycle pulse: an over-length frame was discarded |
| drop_link_o | output | $clog2(N_LINKS) | Link of the discarded frame |
| drop_sub_o | output | 2 | Sub-link of the discarded frame |
| over_budget_o | output | 1 | Booked bandwidth exceeds the line rate |

## Verification
Priority is tested by making three links pending at once with their countdowns already expired, which separates lowest-index selection from selection in arrival order. Spacing is tested with one link kept pending and its grant released at once, using exponents 2, 0 and 7. This exposes an off-by-one in the countdown load or a wrong shift. Sub-link rotation is tested with a gap in the pending pattern, to show that idle sub-links are skipped and the turn wraps around. Length policing is tested with lengths one byte above and exactly at the maximum, and with a write to a neighbouring link, so that a strict-versus-inclusive compare mistake or a write to the wrong link shows up. Every configuration write is followed by a comparison of the overbooking flag against a model of the configuration kept in the bench.

// File: rtl/vlsched_pkg.sv
package vlsched_pkg;

    localparam int SUBS    = 4;
    localparam int SUB_W   = 2;
    localparam int EXP_W   = 3;
    localparam int MAX_EXP = 7;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BUSY = 2'd1,
        PH_DROP = 2'd2
    } phase_t;

endpackage

// File: rtl/vl_gap_timer.sv
module vl_gap_timer
    import vlsched_pkg::*;
#(
    parameter int TICK_CYCLES = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             zero_o
);

    localparam int CNT_W = $clog2(TICK_CYCLES * (1 << MAX_EXP) + 1);
    localparam logic [CNT_W-1:0] TICK_V = CNT_W'(TICK_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            // Load gap-1 so the link is eligible again exactly one gap later.
            cnt_d = (TICK_V << exp_i) - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    a_r4_load_when_expired: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> zero_o);

    a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/vl_sub_picker.sv
module vl_sub_picker
    import vlsched_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUBS-1:0]  pend_i,
    input  logic             adv_i,
    input  logic [SUB_W-1:0] adv_sub_i,
    output logic             any_o,
    output logic [SUB_W-1:0] sel_o
);

    logic [SUB_W-1:0] ptr_d, ptr_q;

    always_comb begin
        any_o = 1'b0;
        sel_o = ptr_q;
        // Descending scan: the smallest offset from the pointer wins.
        for (int k = SUBS - 1; k >= 0; k--) begin
            if (pend_i[SUB_W'(ptr_q + SUB_W'(k))]) begin
                any_o = 1'b1;
                sel_o = SUB_W'(ptr_q + SUB_W'(k));
            end
        end
        ptr_d = ptr_q;
        if (adv_i) ptr_d = SUB_W'(adv_sub_i + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    a_r6_sel_pending: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> pend_i[sel_o]);

    a_r6_adv_pending: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> pend_i[adv_sub_i]);

endmodule

// File: rtl/vl_budget_check.sv
module vl_budget_check
    import vlsched_pkg::*;
#(
    parameter int N_LINKS        = 8,
    parameter int LEN_W          = 11,
    parameter int BYTES_PER_TICK = 12500
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_LINKS-1:0][EXP_W-1:0]  exp_i,
    input  logic [N_LINKS-1:0][LEN_W-1:0]  lmax_i,
    output logic                           over_o
);

    localparam int SUM_W = LEN_W + MAX_EXP + $clog2(N_LINKS) + 1;
    localparam int LIM_W = $clog2(BYTES_PER_TICK + 1) + MAX_EXP;
    localparam int ACC_W = (SUM_W > LIM_W) ? SUM_W : LIM_W;
    localparam logic [ACC_W-1:0] LIMIT = ACC_W'(BYTES_PER_TICK) << MAX_EXP;

    logic [ACC_W-1:0] sum;
    logic             over_d, over_q;

    always_comb begin
        sum = '0;
        // Each link books lmax bytes per 2^e ticks; scale to a 128-tick window.
        for (int l = 0; l < N_LINKS; l++) begin
            sum = sum + (ACC_W'(lmax_i[l]) << (EXP_W'(MAX_EXP) - exp_i[l]));
        end
        over_d = (sum > LIMIT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) over_q <= 1'b0;
        else        over_q <= over_d;
    end

    assign over_o = over_q;

endmodule

// File: rtl/vl_gap_sched.sv
module vl_gap_sched
    import vlsched_pkg::*;
#(
    parameter int N_LINKS        = 8,
    parameter int LEN_W          = 11,
    parameter int TICK_CYCLES    = 100000,
    parameter int DEF_LMAX       = 1518,
    parameter int BYTES_PER_TICK = 12500,
    localparam int IDX_W         = $clog2(N_LINKS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_LINKS*SUBS-1:0]       pend_i,
    input  logic [N_LINKS*SUBS*LEN_W-1:0] flen_i,
    input  logic                          done_i,
    input  logic                          cfg_we_i,
    input  logic [IDX_W-1:0]              cfg_link_i,
    input  logic [EXP_W-1:0]              cfg_exp_i,
    input  logic [LEN_W-1:0]              cfg_lmax_i,
    output logic [N_LINKS-1:0]            grant_o,
    output logic [IDX_W-1:0]              grant_link_o,
    output logic [SUB_W-1:0]              grant_sub_o,
    output logic                          drop_o,
    output logic [IDX_W-1:0]              drop_link_o,
    output logic [SUB_W-1:0]              drop_sub_o,
    output logic                          over_budget_o
);

    typedef struct packed {
        phase_t                          ph;
        logic [N_LINKS-1:0]              grant;
        logic [IDX_W-1:0]                link;
        logic [SUB_W-1:0]                sub;
        logic                            drop;
        logic [IDX_W-1:0]                drop_link;
        logic [SUB_W-1:0]                drop_sub;
        logic [N_LINKS-1:0][EXP_W-1:0]   exp;
        logic [N_LINKS-1:0][LEN_W-1:0]   lmax;
    } sched_t;

    sched_t st_d, st_q;

    logic [N_LINKS-1:0] zero, any, load, adv;
    logic [N_LINKS-1:0] elig;
    logic [SUB_W-1:0]   sel_a [N_LINKS];
    logic [LEN_W-1:0]   len_a [N_LINKS][SUBS];

    logic               win_ok;
    logic [IDX_W-1:0]   win;
    logic [SUB_W-1:0]   win_sub;
    logic [LEN_W-1:0]   win_len;

    for (genvar l = 0; l < N_LINKS; l++) begin : g_link
        for (genvar s = 0; s < SUBS; s++) begin : g_sub
            assign len_a[l][s] = flen_i[(l*SUBS+s)*LEN_W +: LEN_W];
        end

        vl_gap_timer #(
            .TICK_CYCLES(TICK_CYCLES)
        ) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load[l]),
            .exp_i  (st_q.exp[l]),
            .zero_o (zero[l])
        );

        vl_sub_picker u_pick (
            .clk       (clk),
            .rst_n     (rst_n),
            .pend_i    (pend_i[l*SUBS +: SUBS]),
            .adv_i     (adv[l]),
            .adv_sub_i (sel_a[l]),
            .any_o     (any[l]),
            .sel_o     (sel_a[l])
        );

        assign elig[l] = zero[l] & any[l];
    end

    vl_budget_check #(
        .N_LINKS        (N_LINKS),
        .LEN_W          (LEN_W),
        .BYTES_PER_TICK (BYTES_PER_TICK)
    ) u_budget (
        .clk    (clk),
        .rst_n  (rst_n),
        .exp_i  (st_q.exp),
        .lmax_i (st_q.lmax),
        .over_o (over_budget_o)
    );

    always_comb begin
        win_ok = 1'b0;
        win    = '0;
        for (int l = N_LINKS - 1; l >= 0; l--) begin
            if (elig[l]) begin
                win_ok = 1'b1;
                win    = IDX_W'(l);
            end
        end
        win_sub = sel_a[win];
        win_len = len_a[win][win_sub];
    end

    always_comb begin
        st_d      = st_q;
        st_d.drop = 1'b0;
        load      = '0;
        adv       = '0;

        if (cfg_we_i && (int'(cfg_link_i) < N_LINKS)) begin
            st_d.exp[cfg_link_i]  = cfg_exp_i;
            st_d.lmax[cfg_link_i] = cfg_lmax_i;
        end

        unique case (st_q.ph)
            PH_IDLE: begin
                if (win_ok) begin
                    adv[win] = 1'b1;
                    if (win_len > st_q.lmax[win]) begin
                        st_d.drop      = 1'b1;
                        st_d.drop_link = win;
                        st_d.drop_sub  = win_sub;
                        st_d.ph        = PH_DROP;
                    end else begin
                        st_d.grant      = '0;
                        st_d.grant[win] = 1'b1;
                        st_d.link       = win;
                        st_d.sub        = win_sub;
                        load[win]       = 1'b1;
                        st_d.ph         = PH_BUSY;
                    end
                end
            end
            PH_BUSY: begin
                if (done_i) begin
                    st_d.grant = '0;
                    st_d.ph    = PH_IDLE;
                end
            end
            PH_DROP: begin
                // One quiet cycle lets the queue pop the discarded frame.
                st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int l = 0; l < N_LINKS; l++) begin
                st_q.lmax[l] <= LEN_W'(DEF_LMAX);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o      = st_q.grant;
    assign grant_link_o = st_q.link;
    assign grant_sub_o  = st_q.sub;
    assign drop_o       = st_q.drop;
    assign drop_link_o  = st_q.drop_link;
    assign drop_sub_o   = st_q.drop_sub;

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    a_r2_index: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0) |-> grant_o[grant_link_o]);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && !done_i) |=> $stable(grant_o));

    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && done_i) |=> (grant_o == '0));

    a_r5_drop_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |-> (grant_o == '0));

    a_r5_drop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |=> !drop_o);

    a_r4_grant_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (load != '0) |-> ((load & zero) == load));

endmodule

// File: tb/vl_gap_sched_bench.sv
module vl_gap_sched_bench;
    import vlsched_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N      = 8;
    localparam int LW     = 11;
    localparam int TICK   = 4;
    localparam int BPT    = 12500;
    localparam int IW     = $clog2(N);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N*4-1:0]       pend = '0;
    logic [N*4*LW-1:0]    flen = '0;
    logic                 done = 1'b0;
    logic                 cfg_we = 1'b0;
    logic [IW-1:0]        cfg_link = '0;
    logic [2:0]           cfg_exp = '0;
    logic [LW-1:0]        cfg_lmax = '0;
    logic [N-1:0]         grant;
    logic [IW-1:0]        grant_link;
    logic [1:0]           grant_sub;
    logic                 drop;
    logic [IW-1:0]        drop_link;
    logic [1:0]           drop_sub;
    logic                 over;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int t_grant = 0;
    bit ended = 0;
    int m_exp [N];
    int m_lmax [N];

    vl_gap_sched #(
        .N_LINKS(N), .LEN_W(LW), .TICK_CYCLES(TICK),
        .DEF_LMAX(1518), .BYTES_PER_TICK(BPT)
    ) u_vl_gap_sched (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .flen_i(flen), .done_i(done),
        .cfg_we_i(cfg_we), .cfg_link_i(cfg_link), .cfg_exp_i(cfg_exp),
        .cfg_lmax_i(cfg_lmax), .grant_o(grant), .grant_link_o(grant_link),
        .grant_sub_o(grant_sub), .drop_o(drop), .drop_link_o(drop_link),
        .drop_sub_o(drop_sub), .over_budget_o(over)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input int act, input int want);
        n_chk++;
        if (act != want) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, want);
        end
    endtask

    function automatic int model_over();
        longint sum = 0;
        for (int l = 0; l < N; l++) sum += longint'(m_lmax[l]) << (7 - m_exp[l]);
        return (sum > (longint'(BPT) << 7)) ? 1 : 0;
    endfunction

    task automatic set_frame(input int l, input int s, input int len);
        flen[(l*4+s)*LW +: LW] = LW'(len);
        pend[l*4+s] = 1'b1;
    endtask

    task automatic cfg(input int l, input int e, input int lm);
        @(negedge clk);
        cfg_we = 1'b1; cfg_link = IW'(l); cfg_exp = 3'(e); cfg_lmax = LW'(lm);
        @(negedge clk);
        cfg_we = 1'b0;
        m_exp[l] = e; m_lmax[l] = lm;
        @(negedge clk);
        chk("R8", "overbooking flag after write", int'(over), model_over());
    endtask

    task automatic wait_grant();
        int n = 0;
        while (grant == '0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        t_grant = cyc;
        if (grant == '0) chk("R2", "grant never arrived", 0, 1);
    endtask

    task automatic release_grant(input int l, input int s, input bit keep);
        done = 1'b1;
        if (!keep) pend[l*4+s] = 1'b0;
        @(negedge clk);
        done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "grant after reset", int'(grant), 0);
        chk("R1", "drop after reset", int'(drop), 0);
        chk("R1", "flag after reset", int'(over), 0);
        set_frame(6, 0, 64);
        @(negedge clk);
        chk("R1", "first decision grants link 6", int'(grant), 1 << 6);
        release_grant(6, 0, 0);
    endtask

    task automatic t_hold();
        set_frame(3, 0, 64);
        @(negedge clk);
        chk("R2", "grant one-hot link 3", int'(grant), 1 << 3);
        chk("R2", "grant index", int'(grant_link), 3);
        chk("R6", "grant sub", int'(grant_sub), 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R2", "grant held without done", int'(grant), 1 << 3);
        end
        release_grant(3, 0, 0);
        chk("R2", "grant cleared after done", int'(grant), 0);
    endtask

    task automatic t_priority();
        set_frame(5, 0, 64); set_frame(2, 0, 64); set_frame(7, 0, 64);
        @(negedge clk);
        chk("R3", "lowest index first", int'(grant_link), 2);
        release_grant(2, 0, 0);
        chk("R2", "released before next", int'(grant), 0);
        @(negedge clk);
        chk("R3", "second winner", int'(grant_link), 5);
        release_grant(5, 0, 0);
        @(negedge clk);
        chk("R3", "third winner", int'(grant_link), 7);
        release_grant(7, 0, 0);
    endtask

    task automatic gap_run(input int e);
        int t0;
        cfg(1, e, 1518);
        set_frame(1, 0, 64);
        wait_grant();
        t0 = t_grant;
        release_grant(1, 0, 1);
        wait_grant();
        chk("R4", $sformatf("gap cycles for exponent %0d", e), t_grant - t0, TICK << e);
        release_grant(1, 0, 1);
        t0 = t_grant;
        wait_grant();
        chk("R4", $sformatf("repeat gap exponent %0d", e), t_grant - t0, TICK << e);
        release_grant(1, 0, 0);
        repeat ((TICK << e) + 2) @(negedge clk);
    endtask

    task automatic t_drop();
        cfg(4, 0, 100);
        set_frame(4, 0, 101);
        @(negedge clk);
        chk("R5", "drop pulse", int'(drop), 1);
        chk("R5", "drop link", int'(drop_link), 4);
        chk("R5", "drop sub", int'(drop_sub), 0);
        chk("R5", "no grant on drop", int'(grant), 0);
        pend[4*4+0] = 1'b0;
        @(negedge clk);
        chk("R5", "drop lasts one cycle", int'(drop), 0);
        set_frame(4, 1, 100);
        @(negedge clk);
        chk("R5", "length equal to max granted, gap not started by drop", int'(grant), 1 << 4);
        chk("R6", "sub after dropped one", int'(grant_sub), 1);
        release_grant(4, 1, 0);
    endtask

    task automatic t_rr();
        int want [4] = '{0, 1, 3, 0};
        set_frame(0, 0, 64); set_frame(0, 1, 64); set_frame(0, 3, 64);
        for (int i = 0; i < 4; i++) begin
            wait_grant();
            chk("R6", $sformatf("rotation step %0d", i), int'(grant_sub), want[i]);
            release_grant(0, 0, 1);
        end
        pend[3:0] = '0;
        repeat (TICK + 2) @(negedge clk);
    endtask

    task automatic t_cfg();
        cfg(2, 0, 50);
        set_frame(3, 1, 60);
        @(negedge clk);
        chk("R7", "neighbour keeps its max", int'(grant), 1 << 3);
        release_grant(3, 1, 0);
        set_frame(2, 0, 60);
        @(negedge clk);
        chk("R7", "written max applies", int'(drop), 1);
        chk("R7", "drop on written link", int'(drop_link), 2);
        pend[2*4+0] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_budget();
        for (int l = 0; l < N; l++) cfg(l, 0, 2047);
        chk("R8", "overbooked with all maxed", int'(over), 1);
        for (int l = 0; l < 4; l++) cfg(l, 1, 2047);
        chk("R8", "half rate clears flag", int'(over), 0);
    endtask

    initial begin
        for (int l = 0; l < N; l++) begin m_exp[l] = 0; m_lmax[l] = 1518; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold();
        t_priority();
        gap_run(2);
        gap_run(0);
        gap_run(7);
        t_drop();
        t_rr();
        t_cfg();
        t_budget();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule